// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block arbitrates the interrupt requests of a small microcontroller core. Each source has a request flag, an enable bit and one priority bit that puts it on the high level or the low level. A global enable gates everything. Once per cycle the controller registers all of these inputs. In the following cycle it picks at most one source and raises a one-cycle acknowledge with the 3-bit index of that source. The core then fetches the vector.

Two flip-flops keep track of which levels are in service. Software cannot see or write them. They are held as a four-state machine: `ST_IDLE` (nothing in service), `ST_LOW` (low level in service), `ST_HIGH` (high level in service) and `ST_NEST` (a high service has preempted a low one). The transitions are:

- `ST_IDLE -> ST_LOW` on a low accept.
- `ST_IDLE -> ST_HIGH` on a high accept.
- `ST_LOW -> ST_NEST` on a high accept.
- `ST_LOW -> ST_IDLE` on a return.
- `ST_HIGH -> ST_IDLE` on a return.
- `ST_NEST -> ST_LOW` on a return.
- A return strobe seen in `ST_IDLE` leaves the state unchanged.

Only the return strobe from the core releases a level. A request can therefore be flagged and enabled and still wait forever, if software leaves a service routine without issuing the return. The parameter `HAS_TIMER2` selects five sources (0) or six sources (1).

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `vec_ack_o` is 0, `vec_idx_o` is 0 and no level is in service, so the first enabled request is accepted.
- R2: While the sampled `glb_en_i` is 0, no request is acknowledged.
- R3: A source whose `src_en_i` bit is 0 is never acknowledged, even if its request bit is set.
- R4: A request driven before clock edge k is registered at edge k. The acknowledge rises at edge k+1 and lasts exactly one cycle.
- R5: Among pending requests of one level, the lowest bit index wins. The bits are 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial, 5 = timer 2. `vec_idx_o` carries that bit index.
- R6: When requests of both levels are pending, a high-level one (its `src_hi_i` bit is 1) wins over any low-level one.
- R7: While a low-level service is active, a high-level request is accepted. This is the nesting case.
- R8: While a low-level service is active, no further low-level request is accepted.
- R9: While a high-level service is active, no request of either level is accepted.
- R10: A return strobe clears only the high in-service flag when both flags are set. Low requests stay blocked afterwards.
- R11: A return strobe with only the low flag set clears it, after which a pending enabled low request is accepted.
- R12: No acknowledge is issued at the clock edge that registers a return strobe. A request that was held off is acknowledged at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | NSRC | Request flags, one per source |
| glb_en_i | input | 1 | Global interrupt enable |
| src_en_i | input | NSRC | Per-source enable bits |
| src_hi_i | input | NSRC | Per-source level select, 1 = high |
| reti_i | input | 1 | Return-from-interrupt strobe from the core |
| vec_ack_o | output | 1 | One-cycle acknowledge pulse |
| vec_idx_o | output | 3 | Index of the accepted source, held until the next accept |

## Verification
A table of single-shot request patterns is applied from a fresh reset each time. The patterns are:

- the global enable off, which shows that it gates every source;
- a source enable masking its own request;
- several lows, which separate fixed-order selection from a simple first-bit rule;
- a mixed-level set, which shows that high beats low.

Directed sequences then walk the service states with the request inputs held. They show that a low service blocks lows but admits a high, and that a high service blocks both levels. They also show that a return out of the nested state leaves the low flag set. A final sequence places a return strobe exactly on the decision edge to expose the one-cycle suppression of the acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int unsigned IDX_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_NEST = 2'd3
    } svc_state_t;

endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic         gen_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] hi_i,
    output logic [N-1:0] cand_hi_o,
    output logic [N-1:0] cand_lo_o,
    output logic         gen_o
);

    logic [N-1:0] req_q;
    logic [N-1:0] en_q;
    logic [N-1:0] hi_q;
    logic         gen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
            en_q  <= '0;
            hi_q  <= '0;
            gen_q <= 1'b0;
        end else begin
            req_q <= req_i;
            en_q  <= en_i;
            hi_q  <= hi_i;
            gen_q <= gen_i;
        end
    end

    always_comb begin
        cand_hi_o = req_q & en_q & hi_q & {N{gen_q}};
        cand_lo_o = req_q & en_q & ~hi_q & {N{gen_q}};
    end

    assign gen_o = gen_q;

endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick #(
    parameter int unsigned N = 6
) (
    input  logic [N-1:0]             cand_i,
    output logic                     any_o,
    output logic [irq_pkg::IDX_W-1:0] idx_o
);

    always_comb begin
        any_o = |cand_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                idx_o = irq_pkg::IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter bit HAS_TIMER2 = 1'b1,
    localparam int unsigned NSRC = HAS_TIMER2 ? 6 : 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_req_i,
    input  logic            glb_en_i,
    input  logic [NSRC-1:0] src_en_i,
    input  logic [NSRC-1:0] src_hi_i,
    input  logic            reti_i,
    output logic            vec_ack_o,
    output logic [2:0]      vec_idx_o
);
    import irq_pkg::*;

    localparam int unsigned NLVL = 2;

    logic [NSRC-1:0] cand_hi;
    logic [NSRC-1:0] cand_lo;
    logic            gen_q;
    logic [NLVL-1:0] lvl_any;
    logic [IDX_W-1:0] lvl_idx [NLVL];

    irq_sampler #(.N(NSRC)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (irq_req_i),
        .gen_i     (glb_en_i),
        .en_i      (src_en_i),
        .hi_i      (src_hi_i),
        .cand_hi_o (cand_hi),
        .cand_lo_o (cand_lo),
        .gen_o     (gen_q)
    );

    // level 1 = high, level 0 = low
    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        irq_level_pick #(.N(NSRC)) u_pick (
            .cand_i (g == 1 ? cand_hi : cand_lo),
            .any_o  (lvl_any[g]),
            .idx_o  (lvl_idx[g])
        );
    end

    svc_state_t       st_q, st_d;
    logic             take;
    logic             take_hi;
    logic [IDX_W-1:0] take_idx;
    logic             ack_q;
    logic             ack_hi_q;
    logic [IDX_W-1:0] idx_q;

    // Next state and accept decision
    always_comb begin
        st_d     = st_q;
        take     = 1'b0;
        take_hi  = 1'b0;
        take_idx = '0;
        if (reti_i) begin
            unique case (st_q)
                ST_NEST: st_d = ST_LOW;
                ST_HIGH: st_d = ST_IDLE;
                ST_LOW:  st_d = ST_IDLE;
                ST_IDLE: st_d = ST_IDLE;
            endcase
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (lvl_any[1]) begin
                        take = 1'b1; take_hi = 1'b1; take_idx = lvl_idx[1];
                        st_d = ST_HIGH;
                    end else if (lvl_any[0]) begin
                        take = 1'b1; take_idx = lvl_idx[0];
                        st_d = ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (lvl_any[1]) begin
                        take = 1'b1; take_hi = 1'b1; take_idx = lvl_idx[1];
                        st_d = ST_NEST;
                    end
                end
                ST_HIGH, ST_NEST: begin
                    st_d = st_q;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q    <= 1'b0;
            ack_hi_q <= 1'b0;
            idx_q    <= '0;
        end else begin
            ack_q <= take;
            if (take) begin
                ack_hi_q <= take_hi;
                idx_q    <= take_idx;
            end
        end
    end

    assign vec_ack_o = ack_q;
    assign vec_idx_o = idx_q;

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_ack_o |=> !vec_ack_o);

    assert_gen_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_q |=> !vec_ack_o);

    assert_hi_blocks_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HIGH || st_q == ST_NEST) |=> !vec_ack_o);

    assert_lo_blocks_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOW) |=> !(vec_ack_o && !ack_hi_q));

    assert_ret_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |=> !vec_ack_o);

    assert_nest_ret_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_NEST && reti_i) |=> (st_q == ST_LOW));

    assert_hi_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !reti_i && (|cand_hi)) |=> (vec_ack_o && ack_hi_q));

endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] req = '0;
    logic       gen = 1'b0;
    logic [5:0] en = '0;
    logic [5:0] hi = '0;
    logic       ret = 1'b0;
    logic       ack;
    logic [2:0] idx;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req_i (req),
        .glb_en_i  (gen),
        .src_en_i  (en),
        .src_hi_i  (hi),
        .reti_i    (ret),
        .vec_ack_o (ack),
        .vec_idx_o (idx)
    );

    // {gen, req, en, hi, exp_ack, exp_idx}
    localparam int NV = 10;
    localparam logic [22:0] VEC [NV] = '{
        {1'b0, 6'b000001, 6'b111111, 6'b000000, 1'b0, 3'd0}, // R2
        {1'b1, 6'b000001, 6'b111110, 6'b000000, 1'b0, 3'd0}, // R3
        {1'b1, 6'b000001, 6'b111111, 6'b000000, 1'b1, 3'd0}, // R1
        {1'b1, 6'b101100, 6'b111111, 6'b000000, 1'b1, 3'd2}, // R5
        {1'b1, 6'b110000, 6'b111111, 6'b000000, 1'b1, 3'd4}, // R5
        {1'b1, 6'b100000, 6'b111111, 6'b000000, 1'b1, 3'd5}, // R5
        {1'b1, 6'b000011, 6'b111111, 6'b000010, 1'b1, 3'd1}, // R6
        {1'b1, 6'b111111, 6'b111111, 6'b100000, 1'b1, 3'd5}, // R6
        {1'b1, 6'b000110, 6'b000100, 6'b000000, 1'b1, 3'd2}, // R3
        {1'b1, 6'b111111, 6'b111111, 6'b001100, 1'b1, 3'd2}  // R5 R6
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req = '0; gen = 1'b0; en = '0; hi = '0; ret = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic chk(string rq, logic e_ack, logic [2:0] e_idx, bit cmp_idx);
        total++;
        if (ack !== e_ack || (cmp_idx && idx !== e_idx)) begin
            bad++;
            $display("FAIL %s: ack=%0b idx=%0d expected ack=%0b idx=%0d",
                     rq, ack, idx, e_ack, e_idx);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: ack=%0b idx=%0d expected run to end", ack, idx);
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 reset", 1'b0, 3'd0, 1'b1);

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic e_ack;
            logic [2:0] e_idx;
            do_reset();
            {gen, req, en, hi, e_ack, e_idx} = VEC[v];
            tick();
            tick();
            chk($sformatf("R2/R3/R5/R6 table vec %0d", v), e_ack, e_idx, e_ack);
        end

        // R4, R7, R8, R10, R11, R12: walk the service states
        do_reset();
        gen = 1'b1; en = 6'b111111; hi = 6'b000000; req = 6'b000010;
        tick();
        chk("R4 no ack after first edge", 1'b0, 3'd0, 1'b0);
        tick();
        chk("R4 ack at second edge", 1'b1, 3'd1, 1'b1);
        tick();
        chk("R4 pulse lasts one cycle", 1'b0, 3'd1, 1'b1);
        req = 6'b000011;
        tick(); tick(); tick();
        chk("R8 low blocked during low service", 1'b0, 3'd1, 1'b1);
        req = 6'b001011; hi = 6'b001000;
        tick();
        chk("R7 no ack yet", 1'b0, 3'd1, 1'b0);
        tick();
        chk("R7 high preempts low", 1'b1, 3'd3, 1'b1);
        req = 6'b000011;
        tick();
        chk("R9 nested blocks all", 1'b0, 3'd3, 1'b1);
        ret = 1'b1;
        tick();
        ret = 1'b0;
        chk("R12 no ack on return edge", 1'b0, 3'd3, 1'b1);
        tick(); tick();
        chk("R10 low still held after nested return", 1'b0, 3'd3, 1'b1);
        ret = 1'b1;
        tick();
        ret = 1'b0;
        chk("R12 no ack on second return edge", 1'b0, 3'd3, 1'b1);
        tick();
        chk("R11 low accepted after final return", 1'b1, 3'd0, 1'b1);

        // R9: high service blocks both levels
        do_reset();
        gen = 1'b1; en = 6'b111111; hi = 6'b010000; req = 6'b010000;
        tick(); tick();
        chk("R9 high accepted", 1'b1, 3'd4, 1'b1);
        req = 6'b010011; hi = 6'b010001;
        tick();
        chk("R9 blocked a", 1'b0, 3'd4, 1'b1);
        tick();
        chk("R9 blocked b", 1'b0, 3'd4, 1'b1);
        tick();
        chk("R9 blocked c", 1'b0, 3'd4, 1'b1);
        req = 6'b000011;
        tick();
        ret = 1'b1;
        tick();
        ret = 1'b0;
        chk("R12 return edge silent", 1'b0, 3'd4, 1'b1);
        tick();
        chk("R6 high wins after return", 1'b1, 3'd0, 1'b1);

        // R12: return strobe in idle on the decision edge
        do_reset();
        gen = 1'b1; en = 6'b111111; hi = 6'b000000; req = 6'b000100;
        tick();
        ret = 1'b1;
        tick();
        ret = 1'b0;
        chk("R12 suppressed on return edge", 1'b0, 3'd0, 1'b0);
        tick();
        chk("R12 accepted one edge later", 1'b1, 3'd2, 1'b1);

        finish_run();
    end

endmodule